// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host offers one request at a time through a request/ready handshake, carrying a word address, write data, a write flag and a per-lane byte enable. The controller turns each request into a sequence of active-low strobes: chip enable, output enable, write enable and one select per byte lane. Reads return the captured word with a one-cycle valid pulse.

The memory itself has no clock, so every one of its timing minimums (write pulse width, address-to-write-end, data setup, access times after address and after output enable, output float time) is a nanosecond parameter. The controller turns each into a whole number of its own clock cycles from the parameter giving the clock period. Each access walks idle, setup, strobe, then either a hold cycle (writes) or a turnaround wait (reads). The data bus is split into an output word, a single output-enable and an input word.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever `host_ready` is high, chip enable, output enable and write enable are all high (inactive), every byte select is high, and `mem_dq_oe` is low.
- R2: A write with a nonzero byte enable produces exactly one write-enable low pulse with chip enable low and output enable high. Address, byte selects and driven data are held from the cycle after acceptance through the cycle after write enable rises.
- R3: Byte-enable bit 0 maps to the lower lane (data bits 7:0, select `mem_bsel_n[0]`) and bit 1 to the upper lane (bits 15:8, select `mem_bsel_n[1]`). A write changes only the lanes whose enable bit is 1.
- R4: A read with a nonzero byte enable holds output enable low for RD cycles with write enable high. It never overlaps a write strobe, and `host_rvalid` is high for one cycle, RD+1 rising edges after the accepting edge.
- R5: In returned read data, every lane whose enable bit is 0 reads as zero.
- R6: After a read, output enable stays high for TA cycles before the controller returns to idle. `mem_dq_oe` is never high while output enable is low, so the controller and the memory never drive the bus together.
- R7: A write request with byte enable 00 completes in the accepting cycle: `host_ready` stays high and no strobe moves.
- R8: A read request with byte enable 00 gives `host_rvalid` high with `host_rdata` equal to zero on the next cycle, and no strobe moves.
- R9: Each minimum converts to cycles as ceil(ns / CLK_NS), but at least 1. WR is the largest of the converted write pulse, address-to-write-end, data setup, and the converted write cycle time minus 2. RD is the larger of the converted output-enable access and the converted address access minus 1. TA is the converted output-float time. The write pulse lasts exactly WR cycles.
- R10: `host_ready` is low from the accepting edge until the access ends. A write takes WR+2 cycles and a read RD+TA+1 cycles before the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request; accepted on a rising edge when `host_ready` is high |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_be | input | LANES | Byte-lane enables, bit 0 = lower lane |
| host_ready | output | 1 | Controller idle and able to accept |
| host_rdata | output | DATA_W | Read data, unenabled lanes zero |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bsel_n | output | LANES | Byte-lane selects, active low, bit 0 = lower lane |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Controller drives `mem_dq_o` onto the bus |
| mem_dq_i | input | DATA_W | Data seen on the bus |

## Verification
On every cycle, the assertions check the following: the idle state deselects the memory, the bus driver is never on under a low output enable, and read and write strobes never overlap. They also check that address, selects and write data do not move while chip enable is low, that the strobe widths equal the computed WR and RD counts, and that the zero-enable shortcuts behave as specified. Only the bench scenarios can show the rest, using a bus-level memory model that measures intervals in nanoseconds. These are: that data really lands in the right lanes and reads back, that the capture never happens before the address and output-enable access times (early samples see junk), that write timing minimums are met, and that the memory's float tail never collides with the controller's drivers on a following write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_STROBE = 3'd2,
      ST_HOLD   = 3'd3,
      ST_TURN   = 3'd4
   } ctl_state_t;

   // whole cycles covering a nanosecond minimum, never fewer than one
   function automatic int ns_to_cycles(input int t_ns, input int period_ns);
      int c;
      c = (t_ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wait_ctr.sv
module sram_wait_ctr #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // counter only ever moves downward between loads (R9)
   assert_ctr_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              active,
   input  logic [LANES-1:0]  lane_en,
   input  logic [DATA_W-1:0] bus_in,
   output logic [LANES-1:0]  sel_n,
   output logic [DATA_W-1:0] rd_masked
);

   localparam int LANE_W = DATA_W / LANES;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign sel_n[g] = !(active && lane_en[g]);
      assign rd_masked[g*LANE_W +: LANE_W] =
         lane_en[g] ? bus_in[g*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W            = 18,
   parameter int DATA_W            = 16,
   parameter int LANES             = 2,
   parameter int CLK_NS            = 20,
   parameter int T_WE_PULSE_NS     = 8,
   parameter int T_ADDR_TO_END_NS  = 8,
   parameter int T_DATA_SETUP_NS   = 6,
   parameter int T_WRITE_CYCLE_NS  = 10,
   parameter int T_ADDR_ACCESS_NS  = 10,
   parameter int T_OE_ACCESS_NS    = 4,
   parameter int T_OE_FLOAT_NS     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_write,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [LANES-1:0]  host_be,
   output logic              host_ready,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_bsel_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int WR_CYC = max_int(
      max_int(ns_to_cycles(T_WE_PULSE_NS, CLK_NS), ns_to_cycles(T_ADDR_TO_END_NS, CLK_NS)),
      max_int(ns_to_cycles(T_DATA_SETUP_NS, CLK_NS), ns_to_cycles(T_WRITE_CYCLE_NS, CLK_NS) - 2));
   localparam int RD_CYC = max_int(ns_to_cycles(T_OE_ACCESS_NS, CLK_NS),
                                   ns_to_cycles(T_ADDR_ACCESS_NS, CLK_NS) - 1);
   localparam int TA_CYC  = ns_to_cycles(T_OE_FLOAT_NS, CLK_NS);
   localparam int MAX_CYC = max_int(max_int(WR_CYC, RD_CYC), TA_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam int RUN_W   = CNT_W + 1;

   // elaboration-time parameter checks
   if (LANES < 1 || (DATA_W % LANES) != 0) begin : g_bad_lanes
      $error("DATA_W must split evenly into LANES byte lanes");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("CLK_NS must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   ctl_state_t        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic              write_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvalid_q;

   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_done;
   logic              cmd_phase;
   logic              accept;
   logic              be_zero;
   logic [DATA_W-1:0] rd_masked;

   assign be_zero   = (host_be == '0);
   assign accept    = (st_q == ST_IDLE) && host_req && !be_zero;
   assign cmd_phase = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);

   // cycle timer load decode
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (st_q == ST_SETUP) begin
         tmr_load = 1'b1;
         tmr_val  = write_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
      end else if (st_q == ST_STROBE && tmr_done && !write_q) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(TA_CYC - 1);
      end
   end

   sram_wait_ctr #(.CNT_W(CNT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   sram_lane_map #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
      .active    (cmd_phase),
      .lane_en   (be_q),
      .bus_in    (mem_dq_i),
      .sel_n     (mem_bsel_n),
      .rd_masked (rd_masked)
   );

   // access sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         addr_q   <= '0;
         wdata_q  <= '0;
         be_q     <= '0;
         write_q  <= 1'b0;
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q  <= host_addr;
                  wdata_q <= host_wdata;
                  be_q    <= host_be;
                  write_q <= host_write;
                  st_q    <= ST_SETUP;
               end else if (host_req && be_zero && !host_write) begin
                  rdata_q  <= '0;
                  rvalid_q <= 1'b1;
               end
            end
            ST_SETUP: st_q <= ST_STROBE;
            ST_STROBE: begin
               if (tmr_done) begin
                  if (write_q) begin
                     st_q <= ST_HOLD;
                  end else begin
                     rdata_q  <= rd_masked;
                     rvalid_q <= 1'b1;
                     st_q     <= ST_TURN;
                  end
               end
            end
            ST_HOLD: st_q <= ST_IDLE;
            ST_TURN: begin
               if (tmr_done) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign host_ready  = (st_q == ST_IDLE);
   assign host_rdata  = rdata_q;
   assign host_rvalid = rvalid_q;
   assign mem_addr    = addr_q;
   assign mem_ce_n    = !cmd_phase;
   assign mem_oe_n    = !((st_q == ST_STROBE) && !write_q);
   assign mem_we_n    = !((st_q == ST_STROBE) && write_q);
   assign mem_dq_o    = wdata_q;
   assign mem_dq_oe   = cmd_phase && write_q;

   // strobe run-length counters for the width checks
   logic [RUN_W-1:0] we_run_q;
   logic [RUN_W-1:0] oe_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run_q <= '0;
         oe_run_q <= '0;
      end else begin
         we_run_q <= mem_we_n ? '0 : we_run_q + 1'b1;
         oe_run_q <= mem_oe_n ? '0 : oe_run_q + 1'b1;
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_bsel_n)));

   assert_write_oe_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

   assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bsel_n)));

   assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> mem_we_n);

   assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rvalid && !host_ready) |=> !host_rvalid);

   assert_no_drive_oe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_be0_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ready && host_req && host_write && host_be == '0) |=> (host_ready && mem_ce_n));

   assert_be0_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ready && host_req && !host_write && host_be == '0) |=>
         (host_rvalid && host_rdata == '0 && mem_ce_n));

   assert_we_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_run_q == RUN_W'(WR_CYC)));

   assert_oe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_run_q == RUN_W'(RD_CYC)));

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ready && host_req && host_be != '0) |=> !host_ready);

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;

   localparam int NOM_NS = 3;   // period the controller is told it runs at

   function automatic int cyc(input int ns);
      int c;
      c = (ns + NOM_NS - 1) / NOM_NS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int EXP_W = mx(mx(cyc(8), cyc(8)), mx(cyc(6), cyc(10) - 2));
   localparam int EXP_R = mx(cyc(4), cyc(10) - 1);
   localparam int EXP_T = cyc(4);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_write = 1'b0;
   logic [17:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [1:0]  host_be = '0;
   logic        host_ready;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [17:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n;
   logic [1:0]  mem_bsel_n;
   logic [15:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_i = 16'hE7E7;

   always #10 clk = ~clk;   // 50 MHz

   sram_lane_ctrl #(.CLK_NS(NOM_NS)) i_sram_lane_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
      .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_bsel_n(mem_bsel_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] init_word(input logic [17:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   // ---------------- memory model (bus level, nominal ns) ----------------
   logic [15:0] model_mem [int];
   logic [15:0] shadow    [int];

   function automatic logic [15:0] mget(input logic [17:0] a);
      return model_mem.exists(int'(a)) ? model_mem[int'(a)] : init_word(a);
   endfunction
   function automatic logic [15:0] sget(input logic [17:0] a);
      return shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
   endfunction

   int          addr_age, data_age, oe_age, wlen, w_aage, w_dage, tail;
   int          contention = 0;
   logic [17:0] prev_addr, w_addr;
   logic [15:0] prev_data, w_data, wword;
   logic        prev_oe;
   logic [1:0]  w_lanes, drv;

   always @(negedge clk) begin
      bit act;
      bit rd;
      bit valid;
      logic [15:0] word;
      if (!rst_n) begin
         addr_age = 0; data_age = 0; oe_age = 0; wlen = 0; tail = 0;
         prev_addr = '0; prev_data = '0; prev_oe = 1'b0; drv = 2'b00;
         mem_dq_i = 16'hE7E7;
      end else begin
         act = !mem_ce_n && !mem_we_n && (mem_bsel_n != 2'b11);
         rd  = !mem_ce_n && mem_we_n && !mem_oe_n && (mem_bsel_n != 2'b11);
         addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
         prev_addr = mem_addr;
         if (mem_dq_oe) data_age = (prev_oe && mem_dq_o == prev_data) ? data_age + 1 : 1;
         else data_age = 0;
         prev_data = mem_dq_o;
         prev_oe   = mem_dq_oe;
         oe_age = !mem_oe_n ? oe_age + 1 : 0;
         if (act) begin
            wlen++;
            w_addr = mem_addr; w_data = mem_dq_o; w_lanes = ~mem_bsel_n;
            w_aage = addr_age; w_dage = data_age;
         end else if (wlen > 0) begin
            check(wlen * NOM_NS >= 8, "R2 write pulse ns", wlen * NOM_NS, 8);
            check(w_aage * NOM_NS >= 8, "R9 address to write end ns", w_aage * NOM_NS, 8);
            check(w_dage * NOM_NS >= 6, "R9 data setup ns", w_dage * NOM_NS, 6);
            check(mem_addr == w_addr && mem_dq_oe && mem_dq_o == w_data,
                  "R2 hold after write end", {14'd0, mem_addr}, {14'd0, w_addr});
            wword = mget(w_addr);
            if (w_lanes[0]) wword[7:0]  = w_data[7:0];
            if (w_lanes[1]) wword[15:8] = w_data[15:8];
            model_mem[int'(w_addr)] = wword;
            wlen = 0;
         end
         if (rd) begin
            drv = ~mem_bsel_n;
            tail = 0;
         end else if (drv != 2'b00) begin
            if (tail * NOM_NS < 4) tail++;
            else drv = 2'b00;
         end
         if (mem_dq_oe && drv != 2'b00) contention++;
         valid = rd && (addr_age * NOM_NS >= 10) && (oe_age * NOM_NS >= 4);
         word = mget(mem_addr);
         mem_dq_i[7:0]  = (valid && drv[0]) ? word[7:0]  : 8'hE7;
         mem_dq_i[15:8] = (valid && drv[1]) ? word[15:8] : 8'hE7;
      end
   end

   // ---------------- host driver ----------------
   int          o_ready, o_rvalid, o_we, o_oe, o_ce;
   logic [15:0] o_rdata;

   task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be);
      int n;
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d; host_be = be;
      o_ready = -1; o_rvalid = -1; o_we = 0; o_oe = 0; o_ce = 0; o_rdata = 'x;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         host_req = 1'b0;
         if (!mem_we_n) o_we++;
         if (!mem_oe_n) o_oe++;
         if (!mem_ce_n) o_ce++;
         if (host_rvalid && o_rvalid < 0) begin o_rvalid = n; o_rdata = host_rdata; end
         if (host_ready) o_ready = n;
      end while (!host_ready && n < 60);
      if (wr) begin
         wword = sget(a);
         if (be[0]) wword[7:0]  = d[7:0];
         if (be[1]) wword[15:8] = d[15:8];
         shadow[int'(a)] = wword;
      end
   endtask

   function automatic logic [15:0] exp_read(input logic [17:0] a, input logic [1:0] be);
      logic [15:0] w;
      w = sget(a);
      return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
   endfunction

   task automatic run_checked(input bit wr, input logic [17:0] a, input logic [15:0] d,
                              input logic [1:0] be);
      do_op(wr, a, d, be);
      if (be == 2'b00) begin
         check(o_ready == 1 && o_ce == 0, wr ? "R7 be00 write silent" : "R8 be00 read silent",
               o_ce, 0);
         if (!wr) check(o_rvalid == 1 && o_rdata == 16'h0000, "R8 be00 read zero",
                        o_rdata, 0);
      end else if (wr) begin
         check(o_we == EXP_W, "R9 write pulse cycles", o_we, EXP_W);
         check(o_ready == EXP_W + 3, "R10 write busy length", o_ready, EXP_W + 3);
      end else begin
         check(o_oe == EXP_R, "R4 output enable cycles", o_oe, EXP_R);
         check(o_rvalid == EXP_R + 2, "R4 rvalid timing", o_rvalid, EXP_R + 2);
         check(o_rdata == exp_read(a, be), "R3 R5 read data", o_rdata, exp_read(a, be));
         check(o_ready == EXP_R + EXP_T + 2, "R6 turnaround length", o_ready,
               EXP_R + EXP_T + 2);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check(host_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe
            && mem_bsel_n == 2'b11, "R1 reset state", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(host_ready && !host_rvalid, "R1 idle after reset", host_ready, 1);

      // directed corners
      run_checked(1'b1, 18'h00000, 16'h1234, 2'b11);
      run_checked(1'b0, 18'h00000, 16'h0000, 2'b11);
      check(o_rdata == 16'h1234, "R2 full word write", o_rdata, 16'h1234);
      run_checked(1'b1, 18'h3FFFF, 16'hABCD, 2'b01);
      run_checked(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
      check(o_rdata == {init_word(18'h3FFFF) >> 8, 8'hCD} , "R3 lower lane only",
            o_rdata, {init_word(18'h3FFFF) >> 8, 8'hCD});
      run_checked(1'b1, 18'h3FFFF, 16'h9876, 2'b10);
      run_checked(1'b0, 18'h3FFFF, 16'h0000, 2'b11);
      check(o_rdata == 16'h98CD, "R3 upper lane only", o_rdata, 16'h98CD);
      run_checked(1'b0, 18'h3FFFF, 16'h0000, 2'b10);
      check(o_rdata == 16'h9800, "R5 lower lane zeroed", o_rdata, 16'h9800);
      run_checked(1'b1, 18'h00000, 16'hFFFF, 2'b00);
      run_checked(1'b0, 18'h00000, 16'h0000, 2'b11);
      check(o_rdata == 16'h1234, "R7 be00 write left memory", o_rdata, 16'h1234);
      run_checked(1'b0, 18'h00000, 16'h0000, 2'b00);
      check(host_ready && mem_ce_n && mem_we_n && mem_oe_n, "R1 idle between accesses",
            host_ready, 1);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         logic [17:0] a;
         a = ($urandom % 8 == 0) ? 18'h3FFFF - 18'($urandom % 4) : 18'($urandom % 32);
         run_checked(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
      end

      check(contention == 0, "R6 bus contention cycles", contention, 0);
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule